// File: doc/BRIEF.md
# Polled Flag Bus Token Sequencer

This block drives the almost-full status bus of one device in a chain of multi-queue devices. The per-queue flags come in as one wide vector, active low. The block presents them as a small number of status words, each word covering a contiguous group of queues. Two selection schemes exist. A mode pin sampled while reset is asserted picks one of them, and it stays fixed until the next reset.

In polled mode the devices share the bus by passing a token. The device holding the token puts its words on the bus one per write-clock edge, starting with word 1. It raises a sync output while word 1 is on the bus. It pulses its token output while its last word is on the bus. The next device in the ring then starts its own word 1 on the following edge. A single device closes the ring by feeding its token output back to its token input. After reset only the device with ID 0 starts as holder.

In direct mode the bus holds one word. The word is chosen by the low address bits on any rising edge where the strobe is high and programming has completed.

Top module: `flag_bus_seq`

## Requirements
- R1: The mode is taken from mode_i while rst_ni is low (1 = polled, 0 = direct). Changes on mode_i after reset release have no effect on the outputs.
- R2: In polled mode with dev_id_i = 0 at reset, the first rising edge after reset release puts word 1 on the bus with word_en_o high. With a non-zero ID, word_en_o stays low until tok_i is seen high at an edge.
- R3: While this device holds the bus, words 1, 2, 3 and 4 appear on successive edges. After word 4, word_en_o drops unless tok_i is high at that edge. With tok_o looped to tok_i the sequence repeats 1, 2, 3, 4, 1 without a gap.
- R4: sync_o is high exactly in the cycles where word 1 of this device is on the bus, and low otherwise.
- R5: tok_o is high for exactly the one cycle in which word 4 is on the bus.
- R6: In polled mode, tok_i high at a rising edge puts word 1 on the bus after that edge. This applies even in the middle of a sequence.
- R7: Word k (k = 0..3, word 1 being k = 0) carries flags_i[32k+31:32k] unchanged; a 0 bit means the queue is almost full. Whenever word_en_o is low, word_o is all ones.
- R8: In direct mode, a rising edge with strobe_i high and prog_busy_i low selects word addr_i[1:0]. word_en_o goes high and the choice holds until the next accepted strobe. sync_o and tok_o stay low, and tok_i is ignored.
- R9: In direct mode the strobe has no effect while prog_busy_i is high.
- R10: In polled mode strobe_i and addr_i have no effect, and the outputs after reset and before the first edge are word_en_o, sync_o and tok_o low with word_o all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Asynchronous active-low reset; mode and ID are sampled while low |
| mode_i | input | 1 | 1 = polled, 0 = direct; sampled during reset |
| dev_id_i | input | 3 | Device ID; ID 0 starts as token holder |
| flags_i | input | 128 | Active-low almost-full flags, one per queue |
| tok_i | input | 1 | Token from the previous device |
| strobe_i | input | 1 | Direct-mode word select strobe |
| addr_i | input | 8 | Address; low 2 bits select the word |
| prog_busy_i | input | 1 | High while programming is in progress |
| word_o | output | 32 | Status word on the bus |
| word_en_o | output | 1 | This device drives the bus |
| sync_o | output | 1 | High while word 1 of this device is on the bus |
| tok_o | output | 1 | Token to the next device |

## Verification
The bench builds the block with its defaults: 128 queues split into four 32-bit words, an 8-bit address and a 3-bit ID. With these values every word slice, the wrap from word 4 back to word 1 and a full token ring fall within a few cycles. Random flags, token pulses, strobes and addresses are run in both modes with ID 0 and a non-zero ID. The loopback ring, a mid-sequence token restart and strobes during programming are run as directed cases.

// File: rtl/flag_bus_pkg.sv
package flag_bus_pkg;
  localparam int unsigned DEF_QUEUES = 128;
  localparam int unsigned DEF_WORDS  = 4;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_ID_W   = 3;

  typedef enum logic {
    MODE_DIRECT = 1'b0,
    MODE_POLLED = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/flag_poll_ctrl.sv
module flag_poll_ctrl #(
  parameter int unsigned NUM_WORDS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             tok_i,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             sync_o,
  output logic             tok_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_WORDS - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic             pend_q;
  logic             load;

  assign load = en_i && (pend_q || tok_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      pend_q   <= start_i;
    end else begin
      pend_q <= 1'b0;
      if (load) begin
        active_q <= 1'b1;
        idx_q    <= '0;
      end else if (active_q) begin
        if (idx_q == LAST) begin
          active_q <= 1'b0;
          idx_q    <= '0;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign active_o = active_q;
  assign idx_o    = idx_q;
  assign sync_o   = active_q && (idx_q == '0);
  assign tok_o    = active_q && (idx_q == LAST);
endmodule

// File: rtl/flag_direct_sel.sv
module flag_direct_sel #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SEL_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              strobe_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [SEL_W-1:0]  sel_o,
  output logic              valid_o
);
  logic [SEL_W-1:0] sel_q;
  logic             valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      valid_q <= 1'b0;
    end else if (en_i && strobe_i && !busy_i) begin
      sel_q   <= addr_i[SEL_W-1:0];
      valid_q <= 1'b1;
    end
  end

  assign sel_o   = sel_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/flag_word_mux.sv
module flag_word_mux #(
  parameter int unsigned NUM_QUEUES = 128,
  parameter int unsigned NUM_WORDS  = 4,
  localparam int unsigned WORD_W = NUM_QUEUES / NUM_WORDS,
  localparam int unsigned SEL_W  = $clog2(NUM_WORDS)
) (
  input  logic [NUM_QUEUES-1:0] flags_i,
  input  logic [SEL_W-1:0]      sel_i,
  input  logic                  en_i,
  output logic [WORD_W-1:0]     word_o
);
  logic [WORD_W-1:0] slice [NUM_WORDS];

  for (genvar k = 0; k < NUM_WORDS; k++) begin : g_slice
    assign slice[k] = flags_i[k*WORD_W +: WORD_W];
  end

  // idle bus reads as no queue almost full
  assign word_o = en_i ? slice[sel_i] : '1;
endmodule

// File: rtl/flag_bus_seq.sv
module flag_bus_seq
  import flag_bus_pkg::*;
#(
  parameter int unsigned NUM_QUEUES = DEF_QUEUES,
  parameter int unsigned NUM_WORDS  = DEF_WORDS,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned ID_W       = DEF_ID_W,
  localparam int unsigned WORD_W = NUM_QUEUES / NUM_WORDS,
  localparam int unsigned SEL_W  = $clog2(NUM_WORDS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  mode_i,
  input  logic [ID_W-1:0]       dev_id_i,
  input  logic [NUM_QUEUES-1:0] flags_i,
  input  logic                  tok_i,
  input  logic                  strobe_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  prog_busy_i,
  output logic [WORD_W-1:0]     word_o,
  output logic                  word_en_o,
  output logic                  sync_o,
  output logic                  tok_o
);
  bus_mode_e        mode_q;
  logic             polled;
  logic             start;
  logic             p_active;
  logic [SEL_W-1:0] p_idx;
  logic [SEL_W-1:0] d_sel;
  logic             d_valid;
  logic [SEL_W-1:0] sel;

  // mode is captured while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= bus_mode_e'(mode_i);
  end

  assign polled = (mode_q == MODE_POLLED);
  assign start  = mode_i && (dev_id_i == '0);

  flag_poll_ctrl #(.NUM_WORDS(NUM_WORDS)) u_poll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (polled),
    .start_i (start),
    .tok_i   (tok_i),
    .active_o(p_active),
    .idx_o   (p_idx),
    .sync_o  (sync_o),
    .tok_o   (tok_o)
  );

  flag_direct_sel #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_dsel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (!polled),
    .strobe_i(strobe_i),
    .busy_i  (prog_busy_i),
    .addr_i  (addr_i),
    .sel_o   (d_sel),
    .valid_o (d_valid)
  );

  assign sel       = polled ? p_idx : d_sel;
  assign word_en_o = polled ? p_active : d_valid;

  flag_word_mux #(.NUM_QUEUES(NUM_QUEUES), .NUM_WORDS(NUM_WORDS)) u_mux (
    .flags_i(flags_i),
    .sel_i  (sel),
    .en_i   (word_en_o),
    .word_o (word_o)
  );
endmodule

// File: rtl/flag_bus_seq_chk.sv
module flag_bus_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic polled_i,
  input logic tok_i,
  input logic prog_busy_i,
  input logic word_en_o,
  input logic sync_o,
  input logic tok_o
);
  a_r1_mode_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(polled_i));

  a_r4_sync_drives: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |-> word_en_o);

  a_r5_tok_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_o |=> !tok_o);

  a_r6_tok_loads_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (polled_i && tok_i) |=> sync_o);

  a_r3_second_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_o && !tok_i) |=> (word_en_o && !sync_o));

  a_r8_direct_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !polled_i |-> (!sync_o && !tok_o));

  a_r9_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!polled_i && prog_busy_i && !word_en_o) |=> !word_en_o);
endmodule

bind flag_bus_seq flag_bus_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .polled_i   (mode_q == flag_bus_pkg::MODE_POLLED),
  .tok_i      (tok_i),
  .prog_busy_i(prog_busy_i),
  .word_en_o  (word_en_o),
  .sync_o     (sync_o),
  .tok_o      (tok_o)
);

// File: tb/flag_bus_seq_test.sv
module flag_bus_seq_test;
  localparam int CLK = 10;
  localparam int NQ = 128;
  localparam int NW = 4;
  localparam int WW = NQ / NW;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mode = 1'b1;
  logic [2:0]    dev_id = '0;
  logic [NQ-1:0] flags = '1;
  logic          tok_drv = 1'b0;
  logic          loop = 1'b0;
  logic          strobe = 1'b0;
  logic [7:0]    addr = '0;
  logic          busy = 1'b1;
  logic [WW-1:0] word;
  logic          word_en, sync, tok_o, tok_i;

  int checks = 0;
  int errors = 0;

  bit m_polled, m_pend, m_active, m_dvalid;
  int m_idx, m_sel;

  assign tok_i = loop ? tok_o : tok_drv;

  always #(CLK/2) clk = ~clk;

  flag_bus_seq uut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .dev_id_i(dev_id),
    .flags_i(flags), .tok_i(tok_i), .strobe_i(strobe), .addr_i(addr),
    .prog_busy_i(busy), .word_o(word), .word_en_o(word_en), .sync_o(sync),
    .tok_o(tok_o)
  );

  function automatic logic [WW-1:0] exp_word(logic [NQ-1:0] f, bit en, int s);
    return en ? f[s*WW +: WW] : '1;
  endfunction

  function automatic bit m_en();
    return m_polled ? m_active : m_dvalid;
  endfunction

  function automatic bit m_tok();
    return m_polled && m_active && (m_idx == NW - 1);
  endfunction

  task automatic check(string req);
    logic [WW+2:0] got, exp;
    bit en;
    en  = m_en();
    got = {word, word_en, sync, tok_o};
    exp = {exp_word(flags, en, m_polled ? m_idx : m_sel), en,
           m_polled && m_active && (m_idx == 0), m_tok()};
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic do_reset(bit md, logic [2:0] id);
    rst_ni = 1'b0;
    mode = md;
    dev_id = id;
    repeat (3) @(posedge clk);
    #(CLK/4);
    rst_ni = 1'b1;
    m_polled = md;
    m_pend = md && (id == 0);
    m_active = 0; m_idx = 0; m_dvalid = 0; m_sel = 0;
  endtask

  task automatic step(string req);
    bit t;
    t = loop ? m_tok() : tok_drv;
    if (m_polled) begin
      if (m_pend || t) begin
        m_active = 1; m_idx = 0;
      end else if (m_active) begin
        if (m_idx == NW - 1) begin m_active = 0; m_idx = 0; end
        else m_idx++;
      end
      m_pend = 0;
    end else if (strobe && !busy) begin
      m_dvalid = 1; m_sel = int'(addr[1:0]);
    end
    @(posedge clk);
    #(CLK/4);
    check(req);
  endtask

  task automatic rand_in(bit tok_rand);
    flags  = {$urandom, $urandom, $urandom, $urandom};
    strobe = $urandom_range(0, 1);
    addr   = 8'($urandom);
    mode   = $urandom_range(0, 1);
    if (tok_rand) tok_drv = ($urandom_range(0, 5) == 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // polled, ID 0, loopback ring
    loop = 1'b1;
    do_reset(1'b1, 3'd0);
    check("R10 reset state");
    for (int i = 0; i < 16; i++) begin
      rand_in(0);
      step("R2 R3 R4 R5 R7 loop");
    end
    // polled, no loop: idle after word 4, then random tokens
    loop = 1'b0;
    tok_drv = 1'b0;
    do_reset(1'b1, 3'd0);
    for (int i = 0; i < 6; i++) step("R3 stop after word 4");
    if (word_en !== 1'b0) begin
      errors++; $display("FAIL R3: en %b expected 0", word_en);
    end
    checks++;
    tok_drv = 1'b1; step("R6 token load");
    tok_drv = 1'b0; step("R3 word 2");
    tok_drv = 1'b1; step("R6 mid-sequence restart");
    tok_drv = 1'b0;
    for (int i = 0; i < 120; i++) begin
      rand_in(1);
      step("R6 R7 R10 random polled");
    end
    // polled, non-zero ID waits for token
    tok_drv = 1'b0;
    do_reset(1'b1, 3'd3);
    for (int i = 0; i < 8; i++) begin
      rand_in(0);
      step("R2 idle without token");
    end
    tok_drv = 1'b1; step("R2 first token");
    tok_drv = 1'b0;
    for (int i = 0; i < 5; i++) step("R4 R5 sequence");
    // direct mode
    busy = 1'b1;
    do_reset(1'b0, 3'd0);
    check("R10 direct reset");
    for (int i = 0; i < 20; i++) begin
      rand_in(1);
      step("R9 strobe while busy");
    end
    busy = 1'b0;
    for (int k = 0; k < NW; k++) begin
      strobe = 1'b1; addr = 8'(k) | 8'hA0;
      step("R8 directed select");
      strobe = 1'b0; addr = 8'h03;
      step("R8 hold");
    end
    for (int i = 0; i < 150; i++) begin
      rand_in(1);
      busy = ($urandom_range(0, 3) == 0);
      step("R1 R8 R9 random direct");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule